// File: doc/BRIEF.md
# Descriptor Pointer Queue Manager

This block keeps descriptor pointers in a large set of hardware first-in first-out queues and hands them out again through single 32-bit register accesses. Every queue owns a 16-byte register group starting at 0x2000 + n*0x10. The word at offset 0xC of that group is the queue's port. A write to the port appends a descriptor word: a 32-byte-aligned address in bits 31:5 and a size code, (descriptor bytes - 24)/4, in bits 4:0. A read from the port removes and returns the oldest word, or returns zero when the queue holds nothing.

Software watches queue occupancy through packed pending-status words, 32 queues per word. A push that turns a completion queue (queue 93 or above) from empty to non-empty raises a sticky completion event in a status register. A push into a full queue is dropped and raises a sticky overflow event. Enable bits select which events drive the interrupt line. A descriptor region base and control word are kept as plain configuration storage for the software that lays out descriptor memory. The block answers every read one cycle after it is accepted. Writes produce no response.

Top module: `qmgr_desc_queue`

## Requirements
- R1: After reset all queues are empty, every pending word, the status register (0x00), the enable register and both region registers read zero, and irq is low.
- R2: Each queue returns the words pushed to it in push order, and each returned word equals the pushed word in all 32 bits (address bits 31:5 and size code bits 4:0).
- R3: A read of the port of an empty queue returns zero and leaves every queue unchanged.
- R4: A push into a queue that already holds DEPTH (4) words is dropped, leaves that queue's contents unchanged and sets overflow status bit 0.
- R5: Pending word i is read at 0x90 + 4*i (i = 0..4), and queue q is flagged at word q/32, bit q%32. The flag is 1 exactly when the queue is non-empty, and a read issued in the cycle after a push or pop already shows the change.
- R6: A push that makes a queue numbered 93 or above non-empty sets completion status bit 2. Pushes to queues below 93 never set it.
- R7: A write to the status register clears each status bit (0 and 2) whose bit in the written value is 1 and keeps the rest, so writing back the value read clears it.
- R8: A write to 0x04 sets enable bits wherever the value has a 1, and a write to 0x08 clears them. Both addresses read back the enable bits. irq is high exactly when some status bit and its enable bit are both 1.
- R9: Queues are independent. Reads of offsets 0x0, 0x4 and 0x8 inside a queue group return zero, and writes to those offsets change no queue.
- R10: The region base register (0x10) keeps bits 31:5 and reads bits 4:0 as zero. The region control register (0x14) keeps the start index in bits 31:16, the size code in bits 11:8 and the count code in bits 4:0, and reads all other bits as zero.
- R11: Every accepted read gives rsp_valid high in the next cycle, with rsp_rdata valid in that cycle. A write or an idle cycle gives rsp_valid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt: some enabled status bit is set |

## Verification
A corrupted head or tail pointer shows up on the next pop of that queue as a wrong or out-of-order word. A wrong occupancy count shows up as a pending bit that disagrees with the model on the next read of that word, or as a missed or spurious overflow or completion event. Status and enable faults appear on irq in the cycle right after the access that caused them. A reference model in the bench mirrors every queue, so any divergence is caught at the first read that touches the damaged state.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int STAT_W = 3;

  localparam logic [31:0] OFS_STAT  = 32'h0000_0000;
  localparam logic [31:0] OFS_ENSET = 32'h0000_0004;
  localparam logic [31:0] OFS_ENCLR = 32'h0000_0008;
  localparam logic [31:0] OFS_RBASE = 32'h0000_0010;
  localparam logic [31:0] OFS_RCTRL = 32'h0000_0014;
  localparam logic [31:0] OFS_PEND  = 32'h0000_0090;
  localparam logic [31:0] OFS_QBASE = 32'h0000_2000;
  localparam logic [3:0]  QPORT_OFS = 4'hC;

  // status bit positions
  localparam int ST_OVF  = 0;
  localparam int ST_CMPL = 2;
  localparam logic [STAT_W-1:0] STAT_MASK = 3'b101;

  localparam logic [31:0] RBASE_MASK = 32'hFFFF_FFE0;
  localparam logic [31:0] RCTRL_MASK = 32'hFFFF_0F1F;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_QPORT, ACC_PEND, ACC_STAT,
    ACC_ENSET, ACC_ENCLR, ACC_RBASE, ACC_RCTRL
  } acc_kind_e;
endpackage

// File: rtl/qm_regdec.sv
module qm_regdec
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES = 160,
  parameter int PEND_WORDS = 5,
  parameter int QIDX_W     = 8,
  parameter int PW_W       = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [QIDX_W-1:0] qidx,
  output logic [PW_W-1:0]   pword
);
  logic [31:0] a32, qoff, poff;

  always_comb begin
    a32   = {{(32-ADDR_W){1'b0}}, addr};
    qoff  = a32 - OFS_QBASE;
    poff  = a32 - OFS_PEND;
    kind  = ACC_NONE;
    qidx  = '0;
    pword = '0;
    if (a32 >= OFS_QBASE && qoff[31:4] < 28'(NUM_QUEUES) && qoff[3:0] == QPORT_OFS) begin
      kind = ACC_QPORT;
      qidx = qoff[QIDX_W+3:4];
    end else if (a32 >= OFS_PEND && poff < 32'(4*PEND_WORDS) && poff[1:0] == 2'b00) begin
      kind  = ACC_PEND;
      pword = poff[PW_W+1:2];
    end else begin
      case (a32)
        OFS_STAT:  kind = ACC_STAT;
        OFS_ENSET: kind = ACC_ENSET;
        OFS_ENCLR: kind = ACC_ENCLR;
        OFS_RBASE: kind = ACC_RBASE;
        OFS_RCTRL: kind = ACC_RCTRL;
        default:   kind = ACC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/qm_queue_store.sv
// Per-queue FIFO pointers plus one shared storage array. DEPTH must be a
// power of two, at least 2, so the pointers wrap on their own.
module qm_queue_store
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES = 160,
  parameter int DEPTH      = 4,
  parameter int QIDX_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  push,
  input  logic                  pop,
  input  logic [QIDX_W-1:0]     qidx,
  input  logic [DATA_W-1:0]     wdata,
  output logic                  full,
  output logic                  empty,
  output logic [DATA_W-1:0]     rd_word,
  output logic [NUM_QUEUES-1:0] nonempty
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int MEM_AW = QIDX_W + PTR_W;

  logic [PTR_W-1:0]  head [NUM_QUEUES];
  logic [PTR_W-1:0]  tail [NUM_QUEUES];
  logic [CNT_W-1:0]  cnt  [NUM_QUEUES];
  logic [DATA_W-1:0] mem  [0:(1<<MEM_AW)-1];
  logic [DATA_W-1:0] rd_q;

  logic do_wr, do_rd;
  logic [MEM_AW-1:0] waddr, raddr;

  assign full  = (cnt[qidx] == CNT_W'(DEPTH));
  assign empty = (cnt[qidx] == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign waddr = {qidx, tail[qidx]};
  assign raddr = {qidx, head[qidx]};

  generate
    for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_ne
      assign nonempty[g] = (cnt[g] != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        head[i] <= '0;
        tail[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      if (do_wr) begin
        tail[qidx] <= tail[qidx] + PTR_W'(1);
        cnt[qidx]  <= cnt[qidx] + CNT_W'(1);
      end
      if (do_rd) begin
        head[qidx] <= head[qidx] + PTR_W'(1);
        cnt[qidx]  <= cnt[qidx] - CNT_W'(1);
      end
    end
  end

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[waddr] <= wdata;
    if (do_rd) rd_q <= mem[raddr];
  end

  assign rd_word = rd_q;
endmodule

// File: rtl/qm_irq_ctrl.sv
module qm_irq_ctrl
  import qm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_wr,
  input  logic              en_set_wr,
  input  logic              en_clr_wr,
  input  logic [STAT_W-1:0] wbits,
  input  logic              ovf_evt,
  input  logic              cmpl_evt,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] en_q,
  output logic              irq
);
  logic [STAT_W-1:0] clr_bits, set_bits, evt_bits;

  always_comb begin
    clr_bits          = stat_wr ? (wbits & STAT_MASK) : '0;
    set_bits          = '0;
    evt_bits          = '0;
    evt_bits[ST_OVF]  = ovf_evt;
    evt_bits[ST_CMPL] = cmpl_evt;
    if (en_set_wr) set_bits = wbits & STAT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      status_q <= (status_q & ~clr_bits) | evt_bits;
      en_q     <= (en_q | set_bits) & ~(en_clr_wr ? (wbits & STAT_MASK) : '0);
    end
  end

  assign irq = |(status_q & en_q);
endmodule

// File: rtl/qmgr_desc_queue.sv
module qmgr_desc_queue
  import qm_pkg::*;
#(
  parameter int NUM_QUEUES  = 160,
  parameter int DEPTH       = 4,
  parameter int COMPL_FIRST = 93
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int PEND_WORDS = (NUM_QUEUES + 31) / 32;
  localparam int QIDX_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
  localparam int PW_W       = (PEND_WORDS > 1) ? $clog2(PEND_WORDS) : 1;

  acc_kind_e         kind;
  logic [QIDX_W-1:0] q_idx;
  logic [PW_W-1:0]   pword;

  logic q_push, q_pop, q_full, q_empty;
  logic [DATA_W-1:0]         mem_word;
  logic [NUM_QUEUES-1:0]     ne_vec;
  logic [PEND_WORDS*32-1:0]  pend_flat;
  logic [STAT_W-1:0]         status_q, en_q;
  logic                      ovf_evt, cmpl_evt;
  logic [DATA_W-1:0]         rbase_q, rctrl_q, rd_mux, reg_rd_q;
  logic                      rsp_valid_q, pop_hit_q;

  qm_regdec #(
    .NUM_QUEUES(NUM_QUEUES), .PEND_WORDS(PEND_WORDS),
    .QIDX_W(QIDX_W), .PW_W(PW_W)
  ) u_dec (
    .addr(req_addr), .kind(kind), .qidx(q_idx), .pword(pword)
  );

  assign q_push = req_valid &&  req_write && (kind == ACC_QPORT);
  assign q_pop  = req_valid && !req_write && (kind == ACC_QPORT);

  qm_queue_store #(
    .NUM_QUEUES(NUM_QUEUES), .DEPTH(DEPTH), .QIDX_W(QIDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .push(q_push), .pop(q_pop), .qidx(q_idx),
    .wdata(req_wdata), .full(q_full), .empty(q_empty),
    .rd_word(mem_word), .nonempty(ne_vec)
  );

  assign ovf_evt  = q_push && q_full;
  assign cmpl_evt = q_push && q_empty && (int'(q_idx) >= COMPL_FIRST);

  qm_irq_ctrl u_irq (
    .clk(clk), .rst(rst),
    .stat_wr  (req_valid && req_write && (kind == ACC_STAT)),
    .en_set_wr(req_valid && req_write && (kind == ACC_ENSET)),
    .en_clr_wr(req_valid && req_write && (kind == ACC_ENCLR)),
    .wbits(req_wdata[STAT_W-1:0]),
    .ovf_evt(ovf_evt), .cmpl_evt(cmpl_evt),
    .status_q(status_q), .en_q(en_q), .irq(irq)
  );

  always_comb begin
    pend_flat = '0;
    pend_flat[NUM_QUEUES-1:0] = ne_vec;
  end

  always_comb begin
    case (kind)
      ACC_PEND:              rd_mux = pend_flat[32*pword +: 32];
      ACC_STAT:              rd_mux = {{(DATA_W-STAT_W){1'b0}}, status_q};
      ACC_ENSET, ACC_ENCLR:  rd_mux = {{(DATA_W-STAT_W){1'b0}}, en_q};
      ACC_RBASE:             rd_mux = rbase_q;
      ACC_RCTRL:             rd_mux = rctrl_q;
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbase_q     <= '0;
      rctrl_q     <= '0;
      rsp_valid_q <= 1'b0;
      reg_rd_q    <= '0;
      pop_hit_q   <= 1'b0;
    end else begin
      if (req_valid && req_write && kind == ACC_RBASE) rbase_q <= req_wdata & RBASE_MASK;
      if (req_valid && req_write && kind == ACC_RCTRL) rctrl_q <= req_wdata & RCTRL_MASK;
      rsp_valid_q <= req_valid && !req_write;
      reg_rd_q    <= rd_mux;
      pop_hit_q   <= q_pop && !q_empty;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = pop_hit_q ? mem_word : reg_rd_q;
endmodule

// File: rtl/qmgr_desc_queue_chk.sv
module qmgr_desc_queue_chk #(
  parameter int QIDX_W      = 8,
  parameter int COMPL_FIRST = 93
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              q_push,
  input logic              q_pop,
  input logic              q_full,
  input logic              q_empty,
  input logic [QIDX_W-1:0] q_idx,
  input logic [2:0]        status_q
);
  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (rst)
    (!rst && req_valid && !req_write) |=> rsp_valid);

  p_no_rsp_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(req_valid && !req_write)) |=> !rsp_valid);

  p_empty_pop_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && q_pop && q_empty) |=> (rsp_rdata == 32'h0));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && q_push && q_full) |=> status_q[0]);

  p_cmpl_event_r6: assert property (@(posedge clk) disable iff (rst)
    (!rst && q_push && q_empty && int'(q_idx) >= COMPL_FIRST) |=> status_q[2]);
endmodule

bind qmgr_desc_queue qmgr_desc_queue_chk #(
  .QIDX_W(QIDX_W), .COMPL_FIRST(COMPL_FIRST)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .q_push(q_push),
  .q_pop(q_pop), .q_full(q_full), .q_empty(q_empty), .q_idx(q_idx),
  .status_q(status_q)
);

// File: tb/qmgr_desc_queue_tb_top.sv
`timescale 1ns/1ps
module qmgr_desc_queue_tb_top;
  localparam int NQ = 160, DEPTH = 4, CF = 93, PW = 5;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, irq;
  logic [31:0] rsp_rdata;

  qmgr_desc_queue dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int n_run = 0, n_fail = 0;

  // reference model
  int          mcnt [NQ];
  int          mhd  [NQ];
  logic [31:0] mdat [NQ][DEPTH];
  logic [2:0]  mst = '0, men = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  function automatic logic [15:0] qport(input int q);
    return 16'(32'h2000 + q * 16 + 12);
  endfunction

  task automatic m_push(input int q, input logic [31:0] w);
    if (mcnt[q] == DEPTH) mst[0] = 1'b1;
    else begin
      if (q >= CF && mcnt[q] == 0) mst[2] = 1'b1;
      mdat[q][(mhd[q] + mcnt[q]) % DEPTH] = w;
      mcnt[q]++;
    end
  endtask

  task automatic m_pop(input int q, output logic [31:0] w);
    if (mcnt[q] == 0) w = '0;
    else begin
      w = mdat[q][mhd[q]];
      mhd[q] = (mhd[q] + 1) % DEPTH;
      mcnt[q]--;
    end
  endtask

  function automatic logic [31:0] m_pend(input int wi);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++)
      if (wi * 32 + b < NQ) r[b] = (mcnt[wi * 32 + b] > 0);
    return r;
  endfunction

  task automatic push(input int q, input logic [31:0] w);
    wr(qport(q), w); m_push(q, w);
  endtask

  task automatic pop_chk(input int q, input string tag);
    logic [31:0] d, e; logic v;
    rd(qport(q), d, v); m_pop(q, e);
    check(tag, d, e);
  endtask

  task automatic pend_chk(input int wi, input string tag);
    logic [31:0] d; logic v;
    rd(16'(32'h90 + 4 * wi), d, v);
    check(tag, d, m_pend(wi));
  endtask

  task automatic stat_chk(input string tag);
    logic [31:0] d; logic v;
    rd(16'h0000, d, v);
    check(tag, d, {29'b0, mst});
  endtask

  function automatic logic [31:0] rnd_word();
    logic [31:0] w = $urandom;
    w[5] = 1'b1;
    return w;
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v;
    int qlist [8] = '{0, 5, 31, 32, 92, 93, 94, 159};
    void'($urandom(32'd20240611));
    for (int i = 0; i < NQ; i++) begin mcnt[i] = 0; mhd[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    stat_chk("R1 status");
    rd(16'h0004, d, v); check("R1 enable", d, 32'h0);
    rd(16'h0010, d, v); check("R1 region base", d, 32'h0);
    rd(16'h0014, d, v); check("R1 region ctrl", d, 32'h0);
    for (int w = 0; w < PW; w++) pend_chk(w, "R1 pending");
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R11 response timing
    rd(16'h0000, d, v); check("R11 rsp_valid after read", {31'b0, v}, 32'h1);
    wr(16'h0020, 32'h0);
    check("R11 rsp_valid after write", {31'b0, rsp_valid}, 32'h0);

    // R2 / R5 order and pending visibility
    push(5, 32'hABCD_0042);
    pend_chk(0, "R5 pending after push q5");
    push(5, 32'h1234_5662);
    push(5, 32'h0000_0020);
    pop_chk(5, "R2 order 1");
    pop_chk(5, "R2 order 2");
    pop_chk(5, "R2 order 3");
    pend_chk(0, "R5 pending after drain q5");
    pop_chk(5, "R3 empty pop");
    pend_chk(0, "R3 no change after empty pop");

    // R4 overflow
    for (int k = 0; k < DEPTH; k++) push(40, 32'h4000_0000 + k * 32 + 2);
    stat_chk("R4 no overflow yet");
    push(40, 32'hDEAD_BEE2);
    stat_chk("R4 overflow flag");
    for (int k = 0; k < DEPTH + 1; k++) pop_chk(40, "R4 contents kept");

    // R7 W1C
    wr(16'h0000, 32'h0); stat_chk("R7 write zero keeps");
    wr(16'h0000, 32'h1); m_st_clear(32'h1); stat_chk("R7 write back clears");

    // R6 completion
    push(92, 32'h9200_0020);
    stat_chk("R6 queue 92 no event");
    push(93, 32'h9300_0020);
    stat_chk("R6 queue 93 event");
    pend_chk(2, "R5 q93 word2 bit29");
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(16'h0004, 32'h4); men = men | 3'b100;
    check("R8 irq enabled", {31'b0, irq}, 32'h1);
    rd(16'h0008, d, v); check("R8 enable readback", d, 32'h4);
    wr(16'h0008, 32'h4); men = men & ~3'b100;
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr(16'h0000, 32'h4); m_st_clear(32'h4); stat_chk("R7 clear completion");
    pop_chk(92, "R2 q92"); pop_chk(93, "R2 q93");

    // R9 other offsets of a group
    wr(16'h2000 + 16'd7 * 16'h10, 32'h5555_5560);
    wr(16'h2004 + 16'd7 * 16'h10, 32'h5555_5560);
    rd(16'h2008 + 16'd7 * 16'h10, d, v); check("R9 offset 8 reads zero", d, 32'h0);
    pend_chk(0, "R9 q7 stays empty");
    pop_chk(7, "R9 q7 empty pop");

    // R10 region registers
    wr(16'h0010, 32'hFFFF_FFFF); rd(16'h0010, d, v); check("R10 base mask", d, 32'hFFFF_FFE0);
    wr(16'h0014, 32'hFFFF_FFFF); rd(16'h0014, d, v); check("R10 ctrl mask", d, 32'hFFFF_0F1F);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int q = qlist[$urandom % 8];
      int op = $urandom % 10;
      logic [31:0] r = $urandom;
      if (op < 4) push(q, rnd_word());
      else if (op < 7) pop_chk(q, "R2 random pop");
      else if (op == 7) pend_chk($urandom % PW, "R5 random pending");
      else if (op == 8) begin
        stat_chk("R7 random status");
        wr(16'h0000, r); m_st_clear(r);
      end else begin
        if (r[31]) begin wr(16'h0004, r); men = men | (r[2:0] & 3'b101); end
        else       begin wr(16'h0008, r); men = men & ~(r[2:0] & 3'b101); end
      end
      check("R8 random irq", {31'b0, irq}, {31'b0, |(mst & men)});
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic m_st_clear(input logic [31:0] w);
    mst = mst & ~(w[2:0] & 3'b101);
  endtask
endmodule